// File: doc/BRIEF.md
# Coupled Dual Capture Timer

This block holds two up-counters that advance on a shared clock whenever a global run bit and a prescaler tick are both high. Each counter has its own capture input pin, resynchronised and edge-detected inside the block. A rising edge on that pin copies the current count into the counter's capture register. Depending on the counter's 3-bit clear-select code, the same edge can also zero the counter.

A single coupling input ties the two counters together. While it is high, a bus write addressed to either counter loads both counters in the same clock edge. A counter whose clear-select asks to follow its peer is zeroed in the same edge as the peer's capture-driven clear. Following works in both directions. With coupling low, the counters are fully independent. Typical use is measuring a pulse period on one pin while a second timebase stays phase-locked to it.

Top module: `dual_sync_timer`

## Requirements
- R1: After reset both counts and both capture registers read 0.
- R2: A counter increments by one on a clock edge only when `run` and `tick` are both high. With no load and no clear, it holds its value otherwise.
- R3: With clear-select 3'b000 a counter never clears. It counts from FFFFh to 0000h.
- R4: With `sync_on` low, a write (`wr_en` high, `wr_sel` 0 selects counter 0 and 1 selects counter 1) loads `wr_data` into the selected counter only.
- R5: With `sync_on` high, a write to either counter loads `wr_data` into both counters on the same edge.
- R6: A capture pin passes through two synchronising flops. A 0-to-1 transition of the synchronised value latches the count into that counter's capture register. This happens on the third clock edge after the pin rises. A falling pin changes neither the capture register nor the count.
- R7: With clear-select 3'b001, the capture edge of R6 also zeroes the counter. The capture register receives the count from before the clear.
- R8: With clear-select 3'b011 and `sync_on` high, a counter is zeroed on the same edge that its peer is zeroed by the peer's own capture clear (3'b001). This holds for counter 0 following counter 1 and for counter 1 following counter 0.
- R9: With clear-select 3'b011 and `sync_on` low, the peer's clear has no effect on the counter.
- R10: A write and a clear reaching the same counter on the same edge: the written value wins.
- R11: Clear-select codes other than 3'b001 and 3'b011 (3'b010, 3'b100 to 3'b111, and 3'b000) never clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Global count-start bit |
| tick | input | 1 | Prescaler enable pulse |
| sync_on | input | 1 | Couples the two counters when high |
| clr_sel0 | input | 3 | Clear-select code of counter 0 |
| clr_sel1 | input | 3 | Clear-select code of counter 1 |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | Write target: 0 = counter 0, 1 = counter 1 |
| wr_data | input | CNT_W | Value written to the counter(s) |
| cap_pin0 | input | 1 | Capture input of counter 0 (asynchronous) |
| cap_pin1 | input | 1 | Capture input of counter 1 (asynchronous) |
| cnt0 | output | CNT_W | Count of counter 0 |
| cnt1 | output | CNT_W | Count of counter 1 |
| cap0 | output | CNT_W | Capture register of counter 0 |
| cap1 | output | CNT_W | Capture register of counter 1 |

## Verification
The bench sweeps all eight clear-select codes of the following counter, with coupling on and off and in both directions. Only code 3'b011 with coupling on may zero the follower. A design that decoded too loosely would clear on 3'b010 or on uncoupled operation, and a one-way link would miss one direction. Each capture is checked against the count two clocks after the pin rose, which exposes a missing or extra synchroniser stage and a capture taken after the clear instead of before it. Further cases cover the FFFFh wrap, a write landing on the capture edge (a wrong priority leaves zero instead of the written value), a falling pin edge, and every run/tick combination.

// File: rtl/dst_pkg.sv
package dst_pkg;
    localparam logic [2:0] SEL_NONE = 3'b000;
    localparam logic [2:0] SEL_CAPT = 3'b001;
    localparam logic [2:0] SEL_PEER = 3'b011;
    localparam int         NUM_LANES = 2;
endpackage

// File: rtl/dst_edge_detect.sv
module dst_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/dst_lane.sv
module dst_lane
    import dst_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic [2:0]   clr_sel,
    input  logic         sync_on,
    input  logic         rise,
    input  logic         peer_capt_clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         capt_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
    } lane_t;

    lane_t st_d, st_q;
    logic  peer_clr;

    assign capt_clr = rise && (clr_sel == SEL_CAPT);
    assign peer_clr = sync_on && (clr_sel == SEL_PEER) && peer_capt_clr;

    always_comb begin
        st_d = st_q;
        if (rise) st_d.cap = st_q.cnt;
        if (load)                       st_d.cnt = load_val;
        else if (capt_clr || peer_clr)  st_d.cnt = '0;
        else if (count_en)              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;
endmodule

// File: rtl/dual_sync_timer.sv
module dual_sync_timer
    import dst_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             sync_on,
    input  logic [2:0]       clr_sel0,
    input  logic [2:0]       clr_sel1,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_pin0,
    input  logic             cap_pin1,
    output logic [CNT_W-1:0] cnt0,
    output logic [CNT_W-1:0] cnt1,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1
);
    logic [NUM_LANES-1:0]            pin_v, rise_v, capt_clr_v, load_v;
    logic [NUM_LANES-1:0][2:0]       sel_v;
    logic [NUM_LANES-1:0][CNT_W-1:0] cnt_v, cap_v;
    logic                            count_en;

    assign pin_v    = {cap_pin1, cap_pin0};
    assign sel_v    = {clr_sel1, clr_sel0};
    assign count_en = run & tick;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign load_v[g] = wr_en && (sync_on || (wr_sel == 1'(g)));

        dst_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_v[g]),
            .rise (rise_v[g])
        );

        dst_lane #(.W(CNT_W)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .count_en     (count_en),
            .clr_sel      (sel_v[g]),
            .sync_on      (sync_on),
            .rise         (rise_v[g]),
            .peer_capt_clr(capt_clr_v[NUM_LANES-1-g]),
            .load         (load_v[g]),
            .load_val     (wr_data),
            .capt_clr     (capt_clr_v[g]),
            .cnt          (cnt_v[g]),
            .cap          (cap_v[g])
        );
    end

    assign cnt0 = cnt_v[0];
    assign cnt1 = cnt_v[1];
    assign cap0 = cap_v[0];
    assign cap1 = cap_v[1];
endmodule

// File: rtl/dst_checker.sv
module dst_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             sync_on,
    input logic [2:0]       clr_sel0,
    input logic [2:0]       clr_sel1,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [1:0]       rise_v,
    input logic [1:0]       capt_clr_v,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] cap0
);
    logic hit0, hit1;
    assign hit0 = wr_en && (sync_on || !wr_sel);
    assign hit1 = wr_en && (sync_on ||  wr_sel);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) && !hit0 && rise_v == 2'b00 |=> $stable(cnt0));

    // R3
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick && clr_sel0 == 3'b000 && !hit0 && cnt0 == '1 |=> cnt0 == '0);

    // R5
    sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sync_on |=> cnt0 == $past(wr_data) && cnt1 == $past(wr_data));

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_v[0] |=> cap0 == $past(cnt0));

    // R7
    capt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_v[0] && clr_sel0 == 3'b001 && !hit0 |=> cnt0 == '0);

    // R8
    peer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_on && clr_sel1 == 3'b011 && capt_clr_v[0] && !hit1 |=> cnt1 == '0);

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit0 |=> cnt0 == $past(wr_data));
endmodule

bind dual_sync_timer dst_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .sync_on   (sync_on),
    .clr_sel0  (clr_sel0),
    .clr_sel1  (clr_sel1),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rise_v    (rise_v),
    .capt_clr_v(capt_clr_v),
    .cnt0      (cnt0),
    .cnt1      (cnt1),
    .cap0      (cap0)
);

// File: tb/test_dual_sync_timer.sv
module test_dual_sync_timer;
    logic        clk = 0, rst_n = 0, run = 0, tick = 0, sync_on = 0;
    logic [2:0]  clr_sel0 = 0, clr_sel1 = 0;
    logic        wr_en = 0, wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic [1:0]  pins = 0;
    logic [15:0] cnt0, cnt1, cap0, cap1;
    logic [1:0][15:0] cnt_b, cap_b;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    dual_sync_timer i_dual_sync_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .sync_on(sync_on),
        .clr_sel0(clr_sel0), .clr_sel1(clr_sel1), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cap_pin0(pins[0]), .cap_pin1(pins[1]),
        .cnt0(cnt0), .cnt1(cnt1), .cap0(cap0), .cap1(cap1)
    );

    assign cnt_b = {cnt1, cnt0};
    assign cap_b = {cap1, cap0};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [15:0] val);
        wr_en = 1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] a_src, a_f, v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt0", cnt0, 16'h0);
        chk("R1 cnt1", cnt1, 16'h0);
        chk("R1 cap0", cap0, 16'h0);
        chk("R1 cap1", cap1, 16'h0);

        // R4 independent writes
        do_write(0, 16'h1234);
        chk("R4 cnt0", cnt0, 16'h1234);
        chk("R4 cnt1", cnt1, 16'h0);
        do_write(1, 16'h0777);
        chk("R4 cnt1", cnt1, 16'h0777);
        chk("R4 cnt0", cnt0, 16'h1234);

        // R2 all run/tick combinations over several cycles
        n = 0;
        for (int k = 0; k < 16; k++) begin
            run = k[0]; tick = k[1] ^ k[2];
            if (run && tick) n++;
            @(negedge clk);
        end
        chk("R2 cnt0", cnt0, 16'h1234 + 16'(n));
        chk("R2 cnt1", cnt1, 16'h0777 + 16'(n));

        // R5 coupled write through either address
        sync_on = 1; run = 0;
        do_write(1, 16'h0ABC);
        chk("R5 cnt0", cnt0, 16'h0ABC);
        chk("R5 cnt1", cnt1, 16'h0ABC);
        do_write(0, 16'h5A5A);
        chk("R5 cnt0", cnt0, 16'h5A5A);
        chk("R5 cnt1", cnt1, 16'h5A5A);
        sync_on = 0;

        // R3 wrap with no clear
        clr_sel0 = 3'b000;
        do_write(0, 16'hFFFE);
        run = 1; tick = 1;
        @(negedge clk);
        chk("R3 FFFF", cnt0, 16'hFFFF);
        @(negedge clk);
        chk("R3 wrap", cnt0, 16'h0000);

        // R6/R7/R8/R9/R11 sweep of follower code, coupling, direction
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                for (int c = 0; c < 8; c++) begin
                    sync_on = 0; run = 1; tick = 1;
                    if (d == 0) begin clr_sel0 = 3'b001; clr_sel1 = 3'(c); end
                    else        begin clr_sel1 = 3'b001; clr_sel0 = 3'(c); end
                    do_write(0, 16'd100 + 16'(c));
                    do_write(1, 16'd700 + 16'(c));
                    sync_on = s[0];
                    pins[d] = 1;
                    a_src = cnt_b[d];
                    a_f   = cnt_b[1-d];
                    repeat (3) @(negedge clk);
                    chk("R6 capture", cap_b[d], a_src + 16'd2);
                    chk("R7 capture clear", cnt_b[d], 16'h0);
                    if (c == 3 && s == 1)
                        chk("R8 follow clear", cnt_b[1-d], 16'h0);
                    else if (c == 3)
                        chk("R9 no follow uncoupled", cnt_b[1-d], a_f + 16'd3);
                    else
                        chk("R11 no clear code", cnt_b[1-d], a_f + 16'd3);
                    pins[d] = 0;
                    sync_on = 0;
                    repeat (4) @(negedge clk);
                end
            end
        end

        // R6 falling edge: no capture and no clear
        run = 0; clr_sel0 = 3'b001;
        do_write(0, 16'h0042);
        pins[0] = 1;
        repeat (4) @(negedge clk);
        v = cap0;
        chk("R6 rise clears", cnt0, 16'h0);
        do_write(0, 16'h0099);
        pins[0] = 0;
        repeat (4) @(negedge clk);
        chk("R6 fall cnt", cnt0, 16'h0099);
        chk("R6 fall cap", cap0, v);

        // R10 write on the capture-clear edge, coupled
        sync_on = 1; clr_sel1 = 3'b011; run = 1; tick = 1;
        pins[0] = 1;
        repeat (2) @(negedge clk);
        a_src = cnt0;
        do_write(1, 16'h3C3C);
        chk("R10 cnt0", cnt0, 16'h3C3C);
        chk("R10 cnt1", cnt1, 16'h3C3C);
        chk("R10 cap0", cap0, a_src);
        pins[0] = 0;
        sync_on = 0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule